// File: doc/BRIEF.md
# SMBus Host with Protected-Window Write Guard

This block is the launch stage of an SMBus host controller. Software sets up a target (7-bit slave address plus a direction bit), a command byte and a data byte through a small register port, then writes a go bit. Before any bus activity, a guard checks the command against a protection bit in the configuration register. When protection is on, any write aimed at slave addresses 0x50 to 0x57 is refused. A refused write never touches SCL or SDA, and it ends at once with done and device-error set, which software sees as a device that did not answer. Reads to the same window, and every transaction outside it, go ahead on the bus.

The protection bit can be written only once after reset. The first software write locks it, even when that write stores 0, and only a reset unlocks it and restores the default given by a parameter. Transactions that are allowed run through a simplified bit-level master. A byte-data write sends address+W, command and data. A byte-data read sends address+W and command, then a repeated START, address+R, receives one byte and answers it with NACK. Both end with a STOP. If any acknowledge slot comes back high, the master goes straight to STOP and flags a device error.

The master state machine has these states: IDLE, START, TX_BIT, TX_ACK, RSTART, RX_BIT, RX_NACK, STOP and FINISH. Each state except IDLE and FINISH lasts four quarter-phases of CLK_DIV clocks each. The transitions are:
- IDLE to START on an allowed go.
- START to TX_BIT.
- TX_BIT to TX_ACK after eight bits.
- TX_ACK to STOP on a NACK or after the data byte.
- TX_ACK to TX_BIT for the next byte of a write.
- TX_ACK to RSTART after the command byte of a read.
- TX_ACK to RX_BIT after address+R.
- RSTART to TX_BIT.
- RX_BIT to RX_NACK after eight bits.
- RX_NACK to STOP.
- STOP to FINISH.
- FINISH to IDLE, and the done pulse is raised in FINISH.

Top module: `smbg_host`

## Requirements
- R1: After reset the status register (offset 0) reads 0, with busy at bit 0, done at bit 1 and device-error at bit 2. The configuration register (offset 1) reads the PROT_DEFAULT parameter value at bit 4 and 0 elsewhere.
- R2: Bit 4 of the configuration register is write-once. The first write after reset stores wdata[4], and every later write leaves it unchanged, including when the first write stored 0.
- R3: With bit 4 = 1, a go (a write of bit0 = 1 to offset 5) whose target register (offset 2: address in [7:1], bit 0 = 1 for read) names a write to an address in 0x50 to 0x57 is refused. Busy stays 0, and done and device-error are both set on the clock that samples the go.
- R4: A refused write leaves SCL and SDA released (high) with no toggling for the whole attempt.
- R5: With bit 4 = 1, a read to an address in 0x50 to 0x57 runs on the bus, and the received byte can be read at offset 4.
- R6: Addresses outside 0x50 to 0x57 (for example 0x4F and 0x58) are never refused, for reads or writes.
- R7: With bit 4 = 0, writes to addresses in 0x50 to 0x57 run on the bus.
- R8: When an acknowledge slot is sampled high (for example, no device at the address), the transaction ends with a STOP, done = 1 and device-error = 1, and the bus is released afterwards.
- R9: Done and device-error are cleared by writing 1 to their bit at offset 0. A 0 leaves them as they are, and each bit clears independently.
- R10: A go written while busy = 1 is ignored. After the running transaction ends, busy stays 0 and the bus stays idle.
- R11: Reset clears the write-once lock and restores the default of bit 4, so a new first write takes effect.
- R12: An allowed byte-data write sends address+W, command and data, so that a later byte-data read with the same command returns the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
A register write is sampled on one rising edge, and its effect on read data is visible in the half cycle that follows. The bench therefore drives at the falling edge and reads status at the next falling edge. A refused write must show done and device-error at exactly that point. An allowed go must show busy there, and the bench then polls busy once per cycle until the transaction finishes, which takes several hundred cycles at the default divider. A scoreboard queue holds the expected flags, read data and bus-activity verdict for each transaction. A monitor pops one entry per go and compares it at those sampling points, while a small slave model on the lines acknowledges 0x56 and 0x58 and stores written bytes.

// File: rtl/smbg_pkg.sv
package smbg_pkg;
    localparam int REG_AW = 3;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] RA_STAT = 3'd0;
    localparam logic [REG_AW-1:0] RA_CFG  = 3'd1;
    localparam logic [REG_AW-1:0] RA_TGT  = 3'd2;
    localparam logic [REG_AW-1:0] RA_CMD  = 3'd3;
    localparam logic [REG_AW-1:0] RA_DATA = 3'd4;
    localparam logic [REG_AW-1:0] RA_GO   = 3'd5;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_TX_BIT, ST_TX_ACK, ST_RSTART,
        ST_RX_BIT, ST_RX_NACK, ST_STOP, ST_FINISH
    } mst_state_t;

    typedef enum logic [1:0] {
        SEG_ADDR_W, SEG_CMD, SEG_DATA, SEG_ADDR_R
    } seg_t;
endpackage

// File: rtl/smbg_guard.sv
module smbg_guard #(
    parameter int         ADDR_BITS = 7,
    parameter logic [6:0] WIN_BASE  = 7'h50,
    parameter int         WIN_LOG2  = 3
) (
    input  logic [ADDR_BITS-1:0] tgt_addr_i,
    input  logic                 tgt_read_i,
    input  logic                 prot_i,
    output logic                 block_o
);
    localparam int TAG_W = ADDR_BITS - WIN_LOG2;

    logic in_window;

    always_comb begin
        in_window = (tgt_addr_i[ADDR_BITS-1:WIN_LOG2] == WIN_BASE[ADDR_BITS-1:WIN_LOG2]);
        block_o   = prot_i && in_window && !tgt_read_i;
    end

    if (TAG_W < 1) begin : g_bad_cfg
        initial $error("window wider than address space");
    end
endmodule

// File: rtl/smbg_regs.sv
module smbg_regs
    import smbg_pkg::*;
#(
    parameter int   ADDR_BITS    = 7,
    parameter int   PROT_BIT     = 4,
    parameter logic PROT_DEFAULT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [REG_DW-1:0]    reg_rdata,
    input  logic                 busy_i,
    input  logic                 mst_done_i,
    input  logic                 mst_err_i,
    input  logic [REG_DW-1:0]    rx_data_i,
    input  logic                 block_i,
    output logic                 go_start_o,
    output logic                 go_block_o,
    output logic [ADDR_BITS-1:0] tgt_addr_o,
    output logic                 tgt_read_o,
    output logic [REG_DW-1:0]    cmd_o,
    output logic [REG_DW-1:0]    wdata_o,
    output logic                 prot_o
);
    logic prot_q, locked_q, done_q, err_q;
    logic [ADDR_BITS-1:0] tgt_addr_q;
    logic tgt_read_q;
    logic [REG_DW-1:0] cmd_q, wdata_q;
    logic wr_stat, wr_cfg, go_req, clr_done, clr_err, set_done, set_err;

    always_comb begin
        wr_stat    = reg_we && (reg_addr == RA_STAT);
        wr_cfg     = reg_we && (reg_addr == RA_CFG);
        go_req     = reg_we && (reg_addr == RA_GO) && reg_wdata[0] && !busy_i;
        go_block_o = go_req && block_i;
        go_start_o = go_req && !block_i;
        clr_done   = wr_stat && reg_wdata[1];
        clr_err    = wr_stat && reg_wdata[2];
        set_done   = go_block_o || mst_done_i;
        set_err    = go_block_o || (mst_done_i && mst_err_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q     <= PROT_DEFAULT;
            locked_q   <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            tgt_addr_q <= '0;
            tgt_read_q <= 1'b0;
            cmd_q      <= '0;
            wdata_q    <= '0;
        end else begin
            if (wr_cfg && !locked_q) begin
                prot_q   <= reg_wdata[PROT_BIT];
                locked_q <= 1'b1;
            end
            if (reg_we && reg_addr == RA_TGT) begin
                tgt_addr_q <= reg_wdata[ADDR_BITS:1];
                tgt_read_q <= reg_wdata[0];
            end
            if (reg_we && reg_addr == RA_CMD)  cmd_q   <= reg_wdata;
            if (reg_we && reg_addr == RA_DATA) wdata_q <= reg_wdata;
            if (set_done)      done_q <= 1'b1;
            else if (clr_done) done_q <= 1'b0;
            if (set_err)       err_q  <= 1'b1;
            else if (clr_err)  err_q  <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_STAT: reg_rdata[2:0] = {err_q, done_q, busy_i};
            RA_CFG:  reg_rdata[PROT_BIT] = prot_q;
            RA_TGT:  reg_rdata = {tgt_addr_q, tgt_read_q};
            RA_CMD:  reg_rdata = cmd_q;
            RA_DATA: reg_rdata = rx_data_i;
            default: reg_rdata = '0;
        endcase
    end

    assign tgt_addr_o = tgt_addr_q;
    assign tgt_read_o = tgt_read_q;
    assign cmd_o      = cmd_q;
    assign wdata_o    = wdata_q;
    assign prot_o     = prot_q;

    // R2: once locked, configuration writes do not move the protection bit
    p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_cfg) |=> (prot_q == $past(prot_q)));

    // R3: a refused go raises done and device-error on the sampling edge
    p_block_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go_block_o |=> (done_q && err_q));

    // R9: write-1 clears done when nothing sets it in the same cycle
    p_w1c_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !set_done) |=> !done_q);
endmodule

// File: rtl/smbg_master.sv
module smbg_master
    import smbg_pkg::*;
#(
    parameter int ADDR_BITS = 7,
    parameter int BYTE_W    = 8,
    parameter int CLK_DIV   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [ADDR_BITS-1:0] tgt_addr_i,
    input  logic                 tgt_read_i,
    input  logic [BYTE_W-1:0]    cmd_i,
    input  logic [BYTE_W-1:0]    wdata_i,
    input  logic                 sda_in,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic [BYTE_W-1:0]    rx_data_o,
    output logic                 scl_low_o,
    output logic                 sda_low_o
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(BYTE_W);

    mst_state_t state, state_nx;
    seg_t seg;
    logic [DIV_W-1:0]  div_cnt;
    logic [1:0]        phase;
    logic [BIT_W-1:0]  bit_idx;
    logic [BYTE_W-1:0] tx_sh, rx_sh, rx_q;
    logic              nack_q, tick, ph_end, sample;

    always_comb begin
        tick   = (div_cnt == DIV_W'(CLK_DIV - 1));
        ph_end = tick && (phase == 2'd3);
        sample = tick && (phase == 2'd2);
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start_i) state_nx = ST_START;
            ST_START:   if (ph_end) state_nx = ST_TX_BIT;
            ST_TX_BIT:  if (ph_end && bit_idx == '0) state_nx = ST_TX_ACK;
            ST_TX_ACK:  if (ph_end) begin
                            if (nack_q) state_nx = ST_STOP;
                            else begin
                                unique case (seg)
                                    SEG_ADDR_W: state_nx = ST_TX_BIT;
                                    SEG_CMD:    state_nx = tgt_read_i ? ST_RSTART : ST_TX_BIT;
                                    SEG_DATA:   state_nx = ST_STOP;
                                    SEG_ADDR_R: state_nx = ST_RX_BIT;
                                    default:    state_nx = ST_STOP;
                                endcase
                            end
                        end
            ST_RSTART:  if (ph_end) state_nx = ST_TX_BIT;
            ST_RX_BIT:  if (ph_end && bit_idx == '0) state_nx = ST_RX_NACK;
            ST_RX_NACK: if (ph_end) state_nx = ST_STOP;
            ST_STOP:    if (ph_end) state_nx = ST_FINISH;
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg     <= SEG_ADDR_W;
            div_cnt <= '0;
            phase   <= '0;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_q    <= '0;
            nack_q  <= 1'b0;
        end else if (state == ST_IDLE) begin
            div_cnt <= '0;
            phase   <= '0;
            if (start_i) begin
                seg     <= SEG_ADDR_W;
                tx_sh   <= {tgt_addr_i, 1'b0};
                bit_idx <= BIT_W'(BYTE_W - 1);
                nack_q  <= 1'b0;
            end
        end else if (state != ST_FINISH) begin
            if (tick) begin
                div_cnt <= '0;
                phase   <= phase + 2'd1;
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
            unique case (state)
                ST_TX_BIT: if (ph_end) begin
                    tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                    bit_idx <= bit_idx - BIT_W'(1);
                end
                ST_TX_ACK: begin
                    if (sample) nack_q <= sda_in;
                    if (ph_end && !nack_q) begin
                        bit_idx <= BIT_W'(BYTE_W - 1);
                        unique case (seg)
                            SEG_ADDR_W: begin seg <= SEG_CMD; tx_sh <= cmd_i; end
                            SEG_CMD: begin
                                if (tgt_read_i) begin
                                    seg   <= SEG_ADDR_R;
                                    tx_sh <= {tgt_addr_i, 1'b1};
                                end else begin
                                    seg   <= SEG_DATA;
                                    tx_sh <= wdata_i;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_RX_BIT: begin
                    if (sample) rx_sh <= {rx_sh[BYTE_W-2:0], sda_in};
                    if (ph_end) bit_idx <= bit_idx - BIT_W'(1);
                end
                ST_RX_NACK: if (ph_end) rx_q <= rx_sh;
                default: ;
            endcase
        end
    end

    // line drivers and flags
    always_comb begin
        scl_low_o = 1'b0;
        sda_low_o = 1'b0;
        unique case (state)
            ST_IDLE, ST_FINISH: ;
            ST_START: begin
                scl_low_o = (phase == 2'd3);
                sda_low_o = (phase != 2'd0);
            end
            ST_TX_BIT: begin
                scl_low_o = (phase < 2'd2);
                sda_low_o = !tx_sh[BYTE_W-1];
            end
            ST_TX_ACK, ST_RX_BIT, ST_RX_NACK: scl_low_o = (phase < 2'd2);
            ST_RSTART: begin
                scl_low_o = (phase == 2'd0) || (phase == 2'd3);
                sda_low_o = (phase >= 2'd2);
            end
            ST_STOP: begin
                scl_low_o = (phase == 2'd0);
                sda_low_o = (phase < 2'd2);
            end
            default: ;
        endcase
        busy_o    = (state != ST_IDLE);
        done_o    = (state == ST_FINISH);
        err_o     = (state == ST_FINISH) && nack_q;
        rx_data_o = rx_q;
    end

    // R4: an idle master never pulls either line
    p_idle_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !$past(start_i)) |-> (!scl_low_o && !sda_low_o));

    // R10: a start only ever launches from IDLE into START
    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i) |=> (state == ST_START));
endmodule

// File: rtl/smbg_host.sv
module smbg_host
    import smbg_pkg::*;
#(
    parameter int         CLK_DIV      = 4,
    parameter logic       PROT_DEFAULT = 1'b1,
    parameter int         PROT_BIT     = 4,
    parameter logic [6:0] WIN_BASE     = 7'h50,
    parameter int         WIN_LOG2     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              scl_low,
    output logic              sda_low,
    input  logic              sda_in
);
    localparam int ADDR_BITS = REG_DW - 1;

    logic busy, mst_done, mst_err, block, go_start, go_block, tgt_read, prot;
    logic [REG_DW-1:0] rx_data, cmd, wdata;
    logic [ADDR_BITS-1:0] tgt_addr;

    smbg_regs #(.ADDR_BITS(ADDR_BITS), .PROT_BIT(PROT_BIT), .PROT_DEFAULT(PROT_DEFAULT)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy),
        .mst_done_i(mst_done), .mst_err_i(mst_err), .rx_data_i(rx_data),
        .block_i(block), .go_start_o(go_start), .go_block_o(go_block),
        .tgt_addr_o(tgt_addr), .tgt_read_o(tgt_read), .cmd_o(cmd),
        .wdata_o(wdata), .prot_o(prot)
    );

    smbg_guard #(.ADDR_BITS(ADDR_BITS), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) u_guard (
        .tgt_addr_i(tgt_addr), .tgt_read_i(tgt_read), .prot_i(prot), .block_o(block)
    );

    smbg_master #(.ADDR_BITS(ADDR_BITS), .BYTE_W(REG_DW), .CLK_DIV(CLK_DIV)) u_master (
        .clk(clk), .rst_n(rst_n), .start_i(go_start), .tgt_addr_i(tgt_addr),
        .tgt_read_i(tgt_read), .cmd_i(cmd), .wdata_i(wdata), .sda_in(sda_in),
        .busy_o(busy), .done_o(mst_done), .err_o(mst_err), .rx_data_o(rx_data),
        .scl_low_o(scl_low), .sda_low_o(sda_low)
    );

    // R3: a refused go never brings the master out of idle
    p_block_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go_block |=> !busy);

    // R4: during a refused go the lines stay released on the next cycle
    p_block_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go_block && !busy) |=> (!scl_low && !sda_low));
endmodule

// File: tb/tb_smbg_host.sv
`timescale 1ns/1ps
module tb_smbg_host;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       dut_scl_low, dut_sda_low, slv_low;
    logic       scl_line, sda_line;

    logic       we0 = 1'b0;
    logic [2:0] addr0 = '0;
    logic [7:0] wdata0 = '0;
    logic [7:0] rdata0;
    logic       scl0, sda0;

    assign scl_line = !dut_scl_low;
    assign sda_line = !(dut_sda_low || slv_low);

    smbg_host #(.CLK_DIV(4), .PROT_DEFAULT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_low(dut_scl_low),
        .sda_low(dut_sda_low), .sda_in(sda_line));

    smbg_host #(.CLK_DIV(4), .PROT_DEFAULT(1'b0)) dut0 (
        .clk(clk), .rst_n(rst_n), .reg_we(we0), .reg_addr(addr0),
        .reg_wdata(wdata0), .reg_rdata(rdata0), .scl_low(scl0),
        .sda_low(sda0), .sda_in(1'b1));

    int checks = 0;
    int errors = 0;
    bit ended = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // bus activity counter
    int toggles = 0;
    logic tscl = 1'b1, tsda = 1'b1;
    always @(posedge clk) begin
        if (scl_line != tscl || sda_line != tsda) toggles++;
        tscl = scl_line;
        tsda = sda_line;
    end

    // slave model: answers 0x56 (bank 0) and 0x58 (bank 1)
    logic [7:0] smem [2][256];
    int bitcnt = 0, bidx = 0, sel = 0;
    bit addressed = 0, rdmode = 0, rdone = 0;
    logic [7:0] sh = '0, ptr = '0;
    logic scl_p = 1'b1, sda_p = 1'b1;
    always @(posedge clk) begin
        if (!rst_n) begin
            slv_low <= 1'b0;
            bitcnt = 0; bidx = 0; addressed = 0; rdone = 0;
            scl_p = 1'b1; sda_p = 1'b1;
        end else begin
            if (scl_p && scl_line && sda_p && !sda_line) begin
                bitcnt = 0; bidx = 0; addressed = 0; rdone = 0; slv_low <= 1'b0;
            end else if (scl_p && scl_line && !sda_p && sda_line) begin
                bitcnt = 0; addressed = 0; slv_low <= 1'b0;
            end else if (!scl_p && scl_line) begin
                if (bitcnt < 8) begin sh = {sh[6:0], sda_line}; bitcnt++; end
            end else if (scl_p && !scl_line) begin
                if (bitcnt == 8) begin
                    bitcnt = 9;
                    if (bidx == 0) begin
                        addressed = (sh[7:1] == 7'h56) || (sh[7:1] == 7'h58);
                        sel = (sh[7:1] == 7'h58) ? 1 : 0;
                        rdmode = sh[0];
                        slv_low <= addressed;
                    end else if (addressed && !rdmode) begin
                        if (bidx == 1) ptr = sh; else smem[sel][ptr] = sh;
                        slv_low <= 1'b1;
                    end else begin
                        slv_low <= 1'b0;
                        rdone = 1;
                    end
                end else if (bitcnt == 9) begin
                    bitcnt = 0; bidx++;
                    if (addressed && rdmode && !rdone) slv_low <= !smem[sel][ptr][7];
                    else slv_low <= 1'b0;
                end else if (bitcnt > 0 && bitcnt < 8 && addressed && rdmode && bidx > 0 && !rdone) begin
                    slv_low <= !smem[sel][ptr][7-bitcnt];
                end
            end
            scl_p = scl_line;
            sda_p = sda_line;
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic wr0(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr0 = a; wdata0 = d; we0 = 1'b1;
        @(negedge clk);
        we0 = 1'b0;
    endtask

    typedef struct {
        string      req;
        bit         blocked;
        bit         exp_err;
        bit         chk_data;
        logic [7:0] exp_data;
        int         tog0;
    } exp_t;
    exp_t sbq[$];
    bit mon_busy = 0;

    task automatic issue(input string req, input logic [6:0] a, input bit rd,
                         input logic [7:0] cmd, input logic [7:0] wd, input bit blocked,
                         input bit exp_err, input bit chk, input logic [7:0] exp_d);
        exp_t it;
        reg_wr(3'd2, {a, rd});
        reg_wr(3'd3, cmd);
        reg_wr(3'd4, wd);
        it.req = req; it.blocked = blocked; it.exp_err = exp_err;
        it.chk_data = chk; it.exp_data = exp_d; it.tog0 = toggles;
        reg_wr(3'd5, 8'h01);
        sbq.push_back(it);
        wait (sbq.size() == 0 && !mon_busy);
    endtask

    // monitor: compares each transaction against the queued expectation
    initial begin
        forever begin
            exp_t it;
            logic [7:0] s, d;
            int n;
            wait (sbq.size() > 0);
            it = sbq.pop_front();
            mon_busy = 1;
            reg_rd(3'd0, s);
            if (it.blocked) begin
                check(s == 8'h06, {it.req, " refused flags"}, s, 8'h06);
                repeat (40) @(negedge clk);
                check(toggles == it.tog0, {it.req, " R4 no bus activity"}, toggles - it.tog0, 0);
                reg_rd(3'd0, s);
                check(s == 8'h06, {it.req, " R3 still idle"}, s, 8'h06);
            end else begin
                check(s[0] == 1'b1, {it.req, " busy after go"}, s, 1);
                n = 0;
                while (s[0] && n < 5000) begin
                    @(negedge clk);
                    reg_rd(3'd0, s);
                    n++;
                end
                check(s == {5'b0, it.exp_err, 2'b10}, {it.req, " end flags"}, s, {5'b0, it.exp_err, 2'b10});
                if (it.chk_data) begin
                    reg_rd(3'd4, d);
                    check(d == it.exp_data, {it.req, " read data"}, d, it.exp_data);
                end
                check(toggles > it.tog0, {it.req, " bus used"}, toggles - it.tog0, 1);
                check(scl_line && sda_line, {it.req, " bus released"}, {scl_line, sda_line}, 3);
            end
            reg_wr(3'd0, 8'h06);
            reg_rd(3'd0, s);
            check(s == 8'h00, "R9 w1c clear both", s, 0);
            mon_busy = 0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int t0;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 256; i++) smem[b][i] = 8'h00;
        smem[0][10] = 8'h3C;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values, both defaults
        reg_rd(3'd0, v); check(v == 8'h00, "R1 status reset", v, 0);
        reg_rd(3'd1, v); check(v == 8'h10, "R1 cfg default 1", v, 8'h10);
        addr0 = 3'd1; #0.2; check(rdata0 == 8'h00, "R1 cfg default 0", rdata0, 0);

        // R2 write-once on the default-0 instance
        wr0(3'd1, 8'h10); addr0 = 3'd1; #0.2;
        check(rdata0 == 8'h10, "R2 first write stores", rdata0, 8'h10);
        wr0(3'd1, 8'h00); addr0 = 3'd1; #0.2;
        check(rdata0 == 8'h10, "R2 second write ignored", rdata0, 8'h10);

        // R3/R4 refused writes, window edges included
        issue("R3 write 0x56", 7'h56, 1'b0, 8'd10, 8'h99, 1, 1, 0, 8'h00);
        issue("R3 write 0x50", 7'h50, 1'b0, 8'd1, 8'h11, 1, 1, 0, 8'h00);
        issue("R3 write 0x57", 7'h57, 1'b0, 8'd1, 8'h11, 1, 1, 0, 8'h00);
        check(smem[0][10] == 8'h3C, "R4 slave memory untouched", smem[0][10], 8'h3C);

        // R5 read in window while protected
        issue("R5 read 0x56", 7'h56, 1'b1, 8'd10, 8'h00, 0, 0, 1, 8'h3C);

        // R6/R12 outside window
        issue("R6 write 0x58", 7'h58, 1'b0, 8'd3, 8'hA5, 0, 0, 0, 8'h00);
        issue("R12 read back 0x58", 7'h58, 1'b1, 8'd3, 8'h00, 0, 0, 1, 8'hA5);
        // R8 no device at 0x4F (also R6: not refused)
        issue("R8 nack 0x4F", 7'h4F, 1'b0, 8'd3, 8'h01, 0, 1, 0, 8'h00);

        // R9 independent clearing
        reg_wr(3'd2, {7'h55, 1'b0});
        reg_wr(3'd5, 8'h01);
        reg_rd(3'd0, v); check(v == 8'h06, "R3 direct refused flags", v, 8'h06);
        reg_wr(3'd0, 8'h00);
        reg_rd(3'd0, v); check(v == 8'h06, "R9 write 0 keeps flags", v, 8'h06);
        reg_wr(3'd0, 8'h04);
        reg_rd(3'd0, v); check(v == 8'h02, "R9 clear err only", v, 8'h02);
        reg_wr(3'd0, 8'h02);
        reg_rd(3'd0, v); check(v == 8'h00, "R9 clear done", v, 8'h00);

        // R2 on main instance: first write stores 0 and locks
        reg_wr(3'd1, 8'h00);
        reg_rd(3'd1, v); check(v == 8'h00, "R2 store 0", v, 0);
        reg_wr(3'd1, 8'h10);
        reg_rd(3'd1, v); check(v == 8'h00, "R2 locked at 0", v, 0);

        // R7 window write allowed when unprotected, R12 read back
        issue("R7 write 0x56", 7'h56, 1'b0, 8'd20, 8'h77, 0, 0, 0, 8'h00);
        issue("R12 read back 0x56", 7'h56, 1'b1, 8'd20, 8'h00, 0, 0, 1, 8'h77);

        // R10 go while busy ignored
        reg_wr(3'd2, {7'h58, 1'b0});
        reg_wr(3'd3, 8'd4);
        reg_wr(3'd4, 8'h5A);
        reg_wr(3'd5, 8'h01);
        reg_wr(3'd5, 8'h01);
        reg_rd(3'd0, v); check(v == 8'h01, "R10 busy during run", v, 1);
        for (int n = 0; n < 5000 && v[0]; n++) begin
            @(negedge clk); reg_rd(3'd0, v);
        end
        check(v == 8'h02, "R10 single completion", v, 8'h02);
        t0 = toggles;
        repeat (200) @(negedge clk);
        reg_rd(3'd0, v);
        check(v == 8'h02, "R10 no second run", v, 8'h02);
        check(toggles == t0, "R10 bus idle after", toggles - t0, 0);
        reg_wr(3'd0, 8'h06);
        issue("R10 data stored once", 7'h58, 1'b1, 8'd4, 8'h00, 0, 0, 1, 8'h5A);

        // R11 reset restores default and unlocks
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        reg_rd(3'd1, v); check(v == 8'h10, "R11 default restored", v, 8'h10);
        addr0 = 3'd1; #0.2; check(rdata0 == 8'h00, "R11 default 0 restored", rdata0, 0);
        reg_wr(3'd1, 8'h00);
        reg_rd(3'd1, v); check(v == 8'h00, "R11 relock first write", v, 0);
        reg_wr(3'd1, 8'h10);
        reg_rd(3'd1, v); check(v == 8'h00, "R11 relocked", v, 0);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule